// File: doc/BRIEF.md
# Shift, Rotate and Status-Bit Execution Unit

This unit is the single-cycle datapath slice of an 8-bit processor that handles one-place shifts, rotates through carry, the nibble exchange and the operations that manipulate individual status bits. The decoder presents an operation select, one operand, a bit index and the current status byte. In the same cycle the unit returns the result byte and the next status byte.

A register on the status path is selected by a parameter. When it is enabled, the next status byte is captured on each clock. When it is disabled, the registered output simply follows the combinational one. Status bits are ordered, from bit 7 down to bit 0: interrupt enable (I), transfer (T), half carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C).

Operation encodings on `op_i` are as follows: 0 pass, 1 shift left, 2 logical shift right, 3 rotate left, 4 rotate right, 5 arithmetic shift right, 6 nibble swap, 7 status set, 8 status clear, 9 bit to T, 10 T to bit. Codes 11 to 15 act as pass.

Top module: `shift_flag_unit`

## Requirements
- R1: Op 1 (shift left) returns operand bits moved up one place with bit 0 = 0, and C takes the old bit 7.
- R2: Op 2 (logical right) returns bits moved down one place with bit 7 = 0, and C takes the old bit 0.
- R3: Op 3 (rotate left) puts old C into bit 0 and old bit 7 into C. Op 4 (rotate right) puts old C into bit 7 and old bit 0 into C.
- R4: Op 5 (arithmetic right) moves bits 7..1 down one place, keeps bit 7 and puts old bit 0 into C.
- R5: After ops 1 to 5, Z = (result == 0), N = result bit 7, V = N xor C and S = N xor V, all using the new values. Status bits 7, 6 and 5 (I, T, H) are unchanged.
- R6: Op 6 exchanges bits 7..4 with bits 3..0 and leaves the status byte unchanged.
- R7: Op 7 sets and op 8 clears the status bit whose position is given by `bit_idx_i` (0 = C ... 7 = I). All other status bits are unchanged, and the result equals the operand.
- R8: Op 9 copies operand bit `bit_idx_i` into T (status bit 6). The result equals the operand and the other status bits are unchanged.
- R9: Op 10 writes T into result bit `bit_idx_i`. The other result bits equal the operand, and the status byte is unchanged.
- R10: With the status register enabled, `sreg_q_o` is 0 during reset and afterwards equals the `sreg_d_o` value of the previous clock.
- R11: Op 0 and ops 11 to 15 return the operand and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select |
| operand_i | input | DATA_W | Operand byte |
| bit_idx_i | input | 3 | Bit index for status and T operations |
| sreg_i | input | 8 | Current status byte |
| result_o | output | DATA_W | Result byte |
| sreg_d_o | output | 8 | Next status byte (combinational) |
| sreg_q_o | output | 8 | Registered next status byte |

## Verification
The bench builds the unit with DATA_W = 8 and the status register enabled, which puts both the same-cycle outputs and the one-clock-delayed status value under comparison. Every operation code, including the five unused codes, is driven against operands 0x00, 0x01, 0x80 and 0xFF with carry both clear and set. All eight status indices are driven for the status-bit and T operations. A long pseudo-random stream of operands, indices and status bytes then mixes operations back to back, so that the delayed status output is checked against a value that changes every cycle.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_SHL  = 4'd1,
        OP_SHR  = 4'd2,
        OP_ROL  = 4'd3,
        OP_ROR  = 4'd4,
        OP_SAR  = 4'd5,
        OP_SWAP = 4'd6,
        OP_FSET = 4'd7,
        OP_FCLR = 4'd8,
        OP_TGET = 4'd9,
        OP_TPUT = 4'd10
    } op_e;

    localparam int STAT_W = 8;
    localparam int SIDX_W = 3;
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    typedef struct packed {
        logic [STAT_W-1:0] sreg;
    } stat_t;
endpackage

// File: rtl/sfu_shifter.sv
module sfu_shifter
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              is_shift
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        res      = a;
        c_out    = c_in;
        is_shift = 1'b1;
        unique case (op)
            OP_SHL: begin
                res   = {a[DATA_W-2:0], 1'b0};
                c_out = a[DATA_W-1];
            end
            OP_SHR: begin
                res   = {1'b0, a[DATA_W-1:1]};
                c_out = a[0];
            end
            OP_ROL: begin
                res   = {a[DATA_W-2:0], c_in};
                c_out = a[DATA_W-1];
            end
            OP_ROR: begin
                res   = {c_in, a[DATA_W-1:1]};
                c_out = a[0];
            end
            OP_SAR: begin
                res   = {a[DATA_W-1], a[DATA_W-1:1]};
                c_out = a[0];
            end
            OP_SWAP: begin
                res      = {a[HALF-1:0], a[DATA_W-1:HALF]};
                is_shift = 1'b0;
            end
            default: is_shift = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfu_bitops.sv
module sfu_bitops
    import sfu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [IDX_W-1:0]  idx,
    input  logic [STAT_W-1:0] s_in,
    output logic [DATA_W-1:0] res,
    output logic [STAT_W-1:0] s_out,
    output logic              is_bitop
);
    logic [SIDX_W-1:0] sidx;
    assign sidx = SIDX_W'(idx);

    always_comb begin
        res      = a;
        s_out    = s_in;
        is_bitop = 1'b1;
        unique case (op)
            OP_FSET: s_out[sidx] = 1'b1;
            OP_FCLR: s_out[sidx] = 1'b0;
            OP_TGET: s_out[F_T]  = a[idx];
            OP_TPUT: res[idx]    = s_in[F_T];
            default: is_bitop = 1'b0;
        endcase
    end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit STATUS_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [2:0]        bit_idx_i,
    input  logic [7:0]        sreg_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        sreg_d_o,
    output logic [7:0]        sreg_q_o
);
    localparam int IDX_W = $clog2(DATA_W);

    op_e               op;
    logic [DATA_W-1:0] sh_res, bo_res;
    logic              sh_c, sh_hit, bo_hit;
    logic [STAT_W-1:0] bo_sreg;
    stat_t             stat_d, stat_q;

    assign op = op_e'(op_i);

    sfu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op(op), .a(operand_i), .c_in(sreg_i[F_C]),
        .res(sh_res), .c_out(sh_c), .is_shift(sh_hit)
    );

    sfu_bitops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bits (
        .op(op), .a(operand_i), .idx(IDX_W'(bit_idx_i)), .s_in(sreg_i),
        .res(bo_res), .s_out(bo_sreg), .is_bitop(bo_hit)
    );

    always_comb begin
        logic n_new, v_new;
        stat_d.sreg = sreg_i;
        result_o    = bo_hit ? bo_res : sh_res;
        n_new       = sh_res[DATA_W-1];
        v_new       = n_new ^ sh_c;
        if (sh_hit) begin
            stat_d.sreg[F_C] = sh_c;
            stat_d.sreg[F_Z] = (sh_res == '0);
            stat_d.sreg[F_N] = n_new;
            stat_d.sreg[F_V] = v_new;
            stat_d.sreg[F_S] = n_new ^ v_new;
        end else if (bo_hit) begin
            stat_d.sreg = bo_sreg;
        end
    end

    assign sreg_d_o = stat_d.sreg;

    generate
        if (STATUS_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q <= '0;
                else        stat_q <= stat_d;
            end
            assign sreg_q_o = stat_q.sreg;

            p_reg_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> sreg_q_o == $past(sreg_d_o));
        end else begin : g_noreg
            assign stat_q   = stat_d;
            assign sreg_q_o = stat_q.sreg;
        end
    endgenerate

    p_shift_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd1 && op_i <= 4'd5) |->
        (sreg_d_o[F_V] == (sreg_d_o[F_N] ^ sreg_d_o[F_C])) &&
        (sreg_d_o[F_S] == (sreg_d_o[F_N] ^ sreg_d_o[F_V])) &&
        (sreg_d_o[7:5] == sreg_i[7:5]) && (sreg_d_o[F_N] == result_o[DATA_W-1]));

    p_swap_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6) |-> sreg_d_o == sreg_i);

    p_flag_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7 || op_i == 4'd8) |->
        ($countones(sreg_d_o ^ sreg_i) <= 1) && (result_o == operand_i) &&
        (sreg_d_o[bit_idx_i] == (op_i == 4'd7)));

    p_tget_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |-> sreg_d_o[F_T] == operand_i[bit_idx_i]);

    p_tput_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |-> (sreg_d_o == sreg_i) &&
        ($countones(result_o ^ operand_i) <= 1) && (result_o[bit_idx_i] == sreg_i[F_T]));

    p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i >= 4'd11) |-> (result_o == operand_i) && (sreg_d_o == sreg_i));
endmodule

// File: tb/tb_shift_flag_unit.sv
module tb_shift_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] operand_i = '0;
    logic [2:0] bit_idx_i = '0;
    logic [7:0] sreg_i = '0;
    logic [7:0] result_o, sreg_d_o, sreg_q_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_flag_unit #(.DATA_W(8), .STATUS_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
        .bit_idx_i(bit_idx_i), .sreg_i(sreg_i), .result_o(result_o),
        .sreg_d_o(sreg_d_o), .sreg_q_o(sreg_q_o)
    );

    function automatic string req_of(input int op);
        case (op)
            1: return "R1/R5";
            2: return "R2/R5";
            3, 4: return "R3/R5";
            5: return "R4/R5";
            6: return "R6";
            7, 8: return "R7";
            9: return "R8";
            10: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic int bitv(input int v, input int k);
        return (v >> k) & 1;
    endfunction

    task automatic model(input int op, input int a, input int idx, input int s,
                         output int r, output int ns);
        int c, n, v, z;
        r = a; ns = s; c = bitv(s, 0);
        case (op)
            1: begin r = (a * 2) % 256; c = a / 128; end
            2: begin r = a / 2; c = a % 2; end
            3: begin r = (a * 2 + bitv(s, 0)) % 256; c = a / 128; end
            4: begin r = a / 2 + bitv(s, 0) * 128; c = a % 2; end
            5: begin r = a / 2 + (a & 128); c = a % 2; end
            6: r = (a % 16) * 16 + a / 16;
            7: ns = s | (1 << idx);
            8: ns = s & ~(1 << idx) & 255;
            9: ns = (s & 8'hBF) | (bitv(a, idx) << 6);
            10: r = (a & ~(1 << idx) & 255) | (bitv(s, 6) << idx);
            default: ;
        endcase
        if (op >= 1 && op <= 5) begin
            n = r / 128; z = (r == 0) ? 1 : 0; v = n ^ c;
            ns = (s & 8'hE0) | ((n ^ v) << 4) | (v << 3) | (n << 2) | (z << 1) | c;
        end
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input int op, input int a, input int idx, input int s);
        int r, ns;
        @(negedge clk);
        op_i = 4'(op); operand_i = 8'(a); bit_idx_i = 3'(idx); sreg_i = 8'(s);
        model(op, a, idx, s, r, ns);
        #1;
        check(req_of(op), "result", int'(result_o), r);
        check(req_of(op), "next status", int'(sreg_d_o), ns);
        exp_q = ns;
        @(posedge clk);
        #1;
        check("R10", "registered status", int'(sreg_q_o), exp_q);
    endtask

    initial begin
        int lfsr = 32'h1D2C3B4A;
        int pats[4] = '{0, 1, 128, 255};
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset status", int'(sreg_q_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // corner operands, every code, carry clear and set
        for (int op = 0; op < 16; op++)
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 2; c++)
                    apply(op, pats[p], (p * 3) % 8, c ? 8'h61 : 8'h9A);
        // every status / bit index
        for (int op = 7; op <= 10; op++)
            for (int i = 0; i < 8; i++) begin
                apply(op, 8'hA5, i, 8'h00);
                apply(op, 8'h5A, i, 8'hFF);
            end
        // pseudo-random mix
        for (int k = 0; k < 600; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >>> 17);
            lfsr = lfsr ^ (lfsr << 5);
            apply((lfsr >> 3) % 11 + ((k % 7 == 0) ? 5 : 0), lfsr & 255,
                  (lfsr >> 11) & 7, (lfsr >> 19) & 255);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule